// File: doc/BRIEF.md
# Video Read-Bus Line Tracker with Line Interrupt

This block watches the read strobe and address bus of a tile-based video chip and works out the frame and line timing from the reads alone. A line is taken to begin when the same nametable-range address (0x2000–0x2FFF) is read three times in a row. The frame is taken to have ended when the video chip stops reading for three CPU cycles. From this it keeps an in-frame flag, a horizontal-blank flag, a line number, a per-line count of tile-name fetches and a per-line count of all reads.

The CPU programs a target line and a read offset within that line. When both match, a pending flag is set. The interrupt request is the pending flag gated by an enable bit. A status read returns the two timing flags and clears the pending flag. A CPU fetch of the NMI vector marks the start of vertical blank, so it resets the frame state.

Top module: `ppu_line_tracker`

## Requirements
- R1: Every video read loads an idle timer with 3. Each `cpu_tick` cycle without a video read decrements a nonzero timer. When the timer reaches zero, in-frame and hblank clear, `scanline` becomes 0xFF and `fetch_cnt` and the repeat count become 0. A video read in the same cycle as a tick reloads the timer instead.
- R2: A read in 0x2000–0x2FFF whose address equals the previous video read's address advances a repeat count. When this makes three identical reads in a row, a line starts. If not in frame, in-frame sets and `scanline` becomes 0; otherwise `scanline` increments. In both cases `read_cnt` and the repeat count become 0 and hblank clears.
- R3: A read with a different address, or with an address outside 0x2000–0x2FFF, clears the repeat count. Such a read never starts a line.
- R4: While in frame, a read in 0x2000–0x2FFF whose low 10 bits are below 0x3C0 increments `fetch_cnt`. This includes the read that starts a line. Reads with low bits at or above 0x3C0 do not count. The count reaching 33 sets hblank.
- R5: Every video read increments `read_cnt`. Pending sets when the updated line and read counts equal the target line and the offset.
- R6: The offset register resets to 135 (0x87). A written value is clamped to the range 1..170.
- R7: `irq` = enable AND pending. A write with `reg_sel`=1 sets enable. A write with `reg_sel`=2 clears both enable and pending. Pending can set while enable is off. The target line is written with `reg_sel`=0 and the offset with `reg_sel`=3.
- R8: A read with `reg_sel`=4 returns {hblank, in-frame, 5'b0, match-this-cycle} on `rd_data` in the same cycle, and clears pending. Any other read returns 0. A match in the same cycle wins over any clear of pending.
- R9: When `vec_rd` is high, in-frame clears, `scanline` becomes 0, pending clears and the stored previous address becomes 0. The repeat count is left as it is.
- R10: After reset, `in_frame`, `in_hblank`, `scanline`, `fetch_cnt`, `read_cnt` and `irq` are all 0, the target line is 0 and enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ppu_rd | input | 1 | One video read in this cycle |
| ppu_addr | input | 14 | Video read address |
| cpu_tick | input | 1 | One CPU cycle elapsed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select (0 target, 1 enable, 2 disable, 3 offset, 4 status) |
| reg_wdata | input | 8 | Register write data |
| vec_rd | input | 1 | CPU fetch of an NMI vector byte |
| irq | output | 1 | Interrupt request |
| rd_data | output | 8 | Register read data |
| in_frame | output | 1 | Rendering in progress |
| in_hblank | output | 1 | Line past its visible fetches |
| scanline | output | 8 | Current line number |
| fetch_cnt | output | 8 | Tile-name fetches in current line |
| read_cnt | output | 8 | Video reads in current line |

## Verification
The hardest state to reach is the instant a line starts. It needs three identical nametable reads after a read that left a different previous address. Otherwise, a stale previous address left over from the last frame makes a line start one read early. Every scenario therefore first lets the idle timer expire and then issues a pattern-table read before the nametable run.

The latest interrupt offset of 170 is reached by issuing long streams of non-nametable reads. These advance the read count without starting lines or counting fetches. The vector-fetch clearing of the previous address is only visible through a split run: two reads, a vector fetch, then two more reads. This run must not start a line, and a third read after it must.

// File: rtl/ppu_lt_pkg.sv
package ppu_lt_pkg;

    localparam int PPU_AW       = 14;
    localparam int CNT_W        = 8;
    localparam int IDLE_RELOAD  = 3;
    localparam int REPEAT_RUN   = 2;
    localparam int HBLANK_FETCH = 33;
    localparam logic [CNT_W-1:0] OFFSET_MIN = 8'd1;
    localparam logic [CNT_W-1:0] OFFSET_MAX = 8'd170;
    localparam logic [CNT_W-1:0] OFFSET_RST = 8'h87;
    localparam logic [9:0]       ATTR_BASE  = 10'h3C0;

    typedef enum logic [2:0] {
        SEL_TARGET = 3'd0,
        SEL_IRQ_ON = 3'd1,
        SEL_IRQ_OFF = 3'd2,
        SEL_OFFSET = 3'd3,
        SEL_STATUS = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic             in_frame;
        logic             hblank;
        logic [CNT_W-1:0] scanline;
        logic [CNT_W-1:0] fetch_cnt;
        logic [CNT_W-1:0] read_cnt;
    } line_state_t;

    function automatic logic is_nt(input logic [PPU_AW-1:0] a);
        return a[13:12] == 2'b10;
    endfunction

    function automatic logic is_name_fetch(input logic [PPU_AW-1:0] a);
        return is_nt(a) && (a[9:0] < ATTR_BASE);
    endfunction

    function automatic logic [CNT_W-1:0] clamp_offset(input logic [CNT_W-1:0] v);
        if (v < OFFSET_MIN) return OFFSET_MIN;
        if (v > OFFSET_MAX) return OFFSET_MAX;
        return v;
    endfunction

endpackage

// File: rtl/ppu_lt_idle.sv
module ppu_lt_idle
    import ppu_lt_pkg::*;
#(
    parameter int RELOAD = IDLE_RELOAD
) (
    input  logic clk,
    input  logic rst,
    input  logic ppu_rd,
    input  logic cpu_tick,
    output logic expire
);
    localparam int W = $clog2(RELOAD + 1);

    logic [W-1:0] cnt;

    assign expire = cpu_tick && !ppu_rd && (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ppu_rd) begin
            cnt <= W'(RELOAD);
        end else if (cpu_tick && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end
endmodule

// File: rtl/ppu_lt_repeat.sv
module ppu_lt_repeat
    import ppu_lt_pkg::*;
#(
    parameter int RUN = REPEAT_RUN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              expire,
    input  logic              vec_rd,
    output logic              line_start
);
    localparam int RW = $clog2(RUN + 1);

    logic [PPU_AW-1:0] last_addr;
    logic [RW-1:0]     rep;
    logic              same;

    assign same       = is_nt(ppu_addr) && (ppu_addr == last_addr);
    assign line_start = ppu_rd && same && (rep == RW'(RUN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            rep       <= '0;
        end else begin
            if (ppu_rd) begin
                last_addr <= ppu_addr;
                rep       <= (same && !line_start) ? rep + RW'(1) : '0;
            end else if (expire) begin
                rep <= '0;
            end
            if (vec_rd) last_addr <= '0;
        end
    end
endmodule

// File: rtl/ppu_lt_lines.sv
module ppu_lt_lines
    import ppu_lt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              line_start,
    input  logic              expire,
    input  logic              vec_rd,
    output line_state_t       st,
    output line_state_t       st_nxt
);
    always_comb begin
        st_nxt = st;
        if (ppu_rd) begin
            st_nxt.read_cnt = st.read_cnt + 1'b1;
            if (line_start) begin
                st_nxt.scanline  = st.in_frame ? st.scanline + 1'b1 : '0;
                st_nxt.in_frame  = 1'b1;
                st_nxt.fetch_cnt = '0;
                st_nxt.read_cnt  = '0;
                st_nxt.hblank    = 1'b0;
            end
            if (st_nxt.in_frame && is_name_fetch(ppu_addr)) begin
                st_nxt.fetch_cnt = st_nxt.fetch_cnt + 1'b1;
                if (st_nxt.fetch_cnt == CNT_W'(HBLANK_FETCH)) st_nxt.hblank = 1'b1;
            end
        end else if (expire) begin
            st_nxt.in_frame  = 1'b0;
            st_nxt.hblank    = 1'b0;
            st_nxt.scanline  = '1;
            st_nxt.fetch_cnt = '0;
        end
        if (vec_rd) begin
            st_nxt.in_frame = 1'b0;
            st_nxt.scanline = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nxt;
    end
endmodule

// File: rtl/ppu_lt_irq.sv
module ppu_lt_irq
    import ppu_lt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             ppu_rd,
    input  logic             vec_rd,
    input  logic [CNT_W-1:0] nxt_line,
    input  logic [CNT_W-1:0] nxt_reads,
    output logic             hit,
    output logic             irq,
    output logic [CNT_W-1:0] offset
);
    logic [CNT_W-1:0] target;
    logic             enable;
    logic             pending;
    logic             clr;

    assign hit = ppu_rd && (nxt_line == target) && (nxt_reads == offset);
    assign clr = (reg_wr && reg_sel == SEL_IRQ_OFF) ||
                 (reg_rd && reg_sel == SEL_STATUS) || vec_rd;
    assign irq = enable && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            target  <= '0;
            offset  <= OFFSET_RST;
            enable  <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    SEL_TARGET:  target <= reg_wdata;
                    SEL_OFFSET:  offset <= clamp_offset(reg_wdata);
                    SEL_IRQ_ON:  enable <= 1'b1;
                    SEL_IRQ_OFF: enable <= 1'b0;
                    default: ;
                endcase
            end
            if (hit)      pending <= 1'b1;
            else if (clr) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/ppu_line_tracker.sv
module ppu_line_tracker
    import ppu_lt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              cpu_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              vec_rd,
    output logic              irq,
    output logic [7:0]        rd_data,
    output logic              in_frame,
    output logic              in_hblank,
    output logic [CNT_W-1:0]  scanline,
    output logic [CNT_W-1:0]  fetch_cnt,
    output logic [CNT_W-1:0]  read_cnt
);
    logic             w_expire;
    logic             w_line_start;
    logic             w_hit;
    logic [CNT_W-1:0] w_offset;
    line_state_t      st, st_nxt;

    ppu_lt_idle u_idle (
        .clk(clk), .rst(rst), .ppu_rd(ppu_rd), .cpu_tick(cpu_tick), .expire(w_expire)
    );

    ppu_lt_repeat u_rep (
        .clk(clk), .rst(rst), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .expire(w_expire), .vec_rd(vec_rd), .line_start(w_line_start)
    );

    ppu_lt_lines u_lines (
        .clk(clk), .rst(rst), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .line_start(w_line_start), .expire(w_expire), .vec_rd(vec_rd),
        .st(st), .st_nxt(st_nxt)
    );

    ppu_lt_irq u_irq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ppu_rd(ppu_rd), .vec_rd(vec_rd),
        .nxt_line(st_nxt.scanline), .nxt_reads(st_nxt.read_cnt),
        .hit(w_hit), .irq(irq), .offset(w_offset)
    );

    assign rd_data   = (reg_rd && reg_sel == SEL_STATUS)
                     ? {st.hblank, st.in_frame, 5'b0, w_hit} : 8'h00;
    assign in_frame  = st.in_frame;
    assign in_hblank = st.hblank;
    assign scanline  = st.scanline;
    assign fetch_cnt = st.fetch_cnt;
    assign read_cnt  = st.read_cnt;
endmodule

// File: rtl/ppu_lt_checker.sv
module ppu_lt_checker (
    input logic       clk,
    input logic       rst,
    input logic       vec_rd,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [2:0] reg_sel,
    input logic       irq,
    input logic       in_frame,
    input logic       in_hblank,
    input logic [7:0] scanline,
    input logic [7:0] fetch_cnt,
    input logic [7:0] read_cnt,
    input logic       expire,
    input logic       line_start,
    input logic       hit,
    input logic [7:0] offset
);
    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (expire && !vec_rd) |=> (!in_frame && !in_hblank && scanline == 8'hFF && fetch_cnt == 8'd0));

    assert_line_start_R2: assert property (@(posedge clk) disable iff (rst)
        (line_start && !vec_rd) |=> (in_frame && !in_hblank && read_cnt == 8'd0));

    assert_hblank_at_33_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(in_hblank) |-> (fetch_cnt == 8'd33));

    assert_offset_range_R6: assert property (@(posedge clk) disable iff (rst)
        (offset >= 8'd1 && offset <= 8'd170));

    assert_disable_drops_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 3'd2 && !hit) |=> !irq);

    assert_status_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel == 3'd4 && !hit) |=> !irq);

    assert_vector_resets_R9: assert property (@(posedge clk) disable iff (rst)
        vec_rd |=> (!in_frame && scanline == 8'd0));
endmodule

bind ppu_line_tracker ppu_lt_checker u_chk (
    .clk(clk), .rst(rst), .vec_rd(vec_rd), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .irq(irq), .in_frame(in_frame), .in_hblank(in_hblank),
    .scanline(scanline), .fetch_cnt(fetch_cnt), .read_cnt(read_cnt),
    .expire(w_expire), .line_start(w_line_start), .hit(w_hit), .offset(w_offset)
);

// File: tb/ppu_line_tracker_test.sv
`timescale 1ns/1ps
module ppu_line_tracker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ppu_rd = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        cpu_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        vec_rd = 1'b0;
    logic        irq, in_frame, in_hblank;
    logic [7:0]  rd_data, scanline, fetch_cnt, read_cnt;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ppu_line_tracker uut (
        .clk(clk), .rst(rst), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .cpu_tick(cpu_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .vec_rd(vec_rd), .irq(irq), .rd_data(rd_data), .in_frame(in_frame),
        .in_hblank(in_hblank), .scanline(scanline), .fetch_cnt(fetch_cnt), .read_cnt(read_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic prd(input logic [13:0] a);
        @(negedge clk); ppu_rd = 1'b1; ppu_addr = a;
        @(negedge clk); ppu_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cpu_tick = 1'b1;
            @(negedge clk); cpu_tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic status(output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_sel = 3'd4;
        #1 v = rd_data;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic vec();
        @(negedge clk); vec_rd = 1'b1;
        @(negedge clk); vec_rd = 1'b0;
    endtask

    // leave the frame, break any stale run, then start line 0
    task automatic new_line();
        tick(3);
        prd(14'h0000);
        repeat (3) prd(14'h2000);
    endtask

    task automatic t_reset();
        check("R10 in_frame", in_frame, 0);
        check("R10 hblank", in_hblank, 0);
        check("R10 scanline", scanline, 0);
        check("R10 fetch_cnt", fetch_cnt, 0);
        check("R10 read_cnt", read_cnt, 0);
        check("R10 irq", irq, 0);
    endtask

    task automatic t_default_offset();
        logic [7:0] s;
        wr(3'd0, 8'd0);
        wr(3'd1, 8'd0);
        new_line();
        check("R2 first line in_frame", in_frame, 1);
        check("R2 first line scanline", scanline, 0);
        for (int i = 1; i <= 134; i++) prd(14'((i * 16) & 12'hFFF));
        check("R6 reset offset no irq at 134", irq, 0);
        prd(14'h0FF0);
        check("R6 reset offset irq at 135", irq, 1);
        status(s);
        check("R8 status value", s, 8'h40);
        check("R8 status clears pending", irq, 0);
    endtask

    task automatic t_line();
        logic [7:0] s;
        new_line();
        check("R4 start read counts fetch", fetch_cnt, 1);
        check("R2 read_cnt zero", read_cnt, 0);
        for (int i = 1; i <= 31; i++) prd(14'h2000 + 14'(i));
        check("R4 fetch 32", fetch_cnt, 32);
        check("R4 no hblank at 32", in_hblank, 0);
        prd(14'h23C0);
        check("R4 attribute not counted", fetch_cnt, 32);
        prd(14'h2020);
        check("R4 hblank at 33", in_hblank, 1);
        status(s);
        check("R8 status hblank", s, 8'hC0);
        repeat (3) prd(14'h2400);
        check("R2 scanline increments", scanline, 1);
        check("R2 hblank cleared", in_hblank, 0);
        check("R2 fetch restarts", fetch_cnt, 1);
    endtask

    task automatic t_break();
        tick(3); prd(14'h0000);
        prd(14'h2000); prd(14'h2000); prd(14'h2001); prd(14'h2000); prd(14'h2000);
        check("R3 differing address breaks run", in_frame, 0);
        prd(14'h2000);
        check("R2 run of three starts", in_frame, 1);
        tick(3); prd(14'h0000);
        prd(14'h2100); prd(14'h2100); prd(14'h0100); prd(14'h2100); prd(14'h2100);
        check("R3 pattern read breaks run", in_frame, 0);
        repeat (3) prd(14'h1000);
        check("R3 identical pattern reads ignored", in_frame, 0);
    endtask

    task automatic t_idle();
        new_line();
        tick(2);
        check("R1 still in frame after 2 ticks", in_frame, 1);
        tick(1);
        check("R1 in_frame cleared", in_frame, 0);
        check("R1 scanline FF", scanline, 8'hFF);
        check("R1 fetch cleared", fetch_cnt, 0);
        new_line();
        tick(2); prd(14'h0000); tick(2);
        check("R1 read reloads timer", in_frame, 1);
        tick(1);
        check("R1 expiry after reload", in_frame, 0);
    endtask

    task automatic t_irq();
        logic [7:0] s;
        wr(3'd3, 8'd3);
        new_line();
        prd(14'h0000); prd(14'h0010);
        check("R5 no irq before offset", irq, 0);
        prd(14'h0020);
        check("R5 irq at offset", irq, 1);
        wr(3'd2, 8'd0);
        check("R7 disable drops irq", irq, 0);
        wr(3'd1, 8'd0);
        check("R7 disable cleared pending", irq, 0);
        wr(3'd3, 8'd0);
        new_line();
        prd(14'h0000);
        check("R6 offset 0 clamps to 1", irq, 1);
        status(s);
        wr(3'd3, 8'd200);
        new_line();
        for (int i = 1; i <= 169; i++) prd(14'((i * 16) & 12'hFFF));
        check("R6 clamp high no irq at 169", irq, 0);
        prd(14'h0000);
        check("R6 offset 200 clamps to 170", irq, 1);
        status(s);
        wr(3'd0, 8'd1); wr(3'd3, 8'd2);
        new_line();
        prd(14'h0000); prd(14'h0010);
        check("R5 target line mismatch", irq, 0);
        repeat (3) prd(14'h2000);
        prd(14'h0000); prd(14'h0010);
        check("R5 target line match", irq, 1);
        wr(3'd2, 8'd0);
        wr(3'd0, 8'd0); wr(3'd3, 8'd1);
        new_line();
        prd(14'h0000);
        check("R7 masked while disabled", irq, 0);
        wr(3'd1, 8'd0);
        check("R7 pending kept while disabled", irq, 1);
    endtask

    task automatic t_vec();
        vec();
        check("R9 in_frame cleared", in_frame, 0);
        check("R9 scanline zero", scanline, 0);
        check("R9 pending cleared", irq, 0);
        prd(14'h2800); prd(14'h2800); vec(); prd(14'h2800); prd(14'h2800);
        check("R9 previous address cleared", in_frame, 0);
        prd(14'h2800);
        check("R9 run restarts after vector", in_frame, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_offset();
        t_line();
        t_break();
        t_idle();
        t_irq();
        t_vec();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule